// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A down-counting watchdog on a small register bus. Software programs a 10-bit timeout, clears the halt bit to start counting, and then keeps the count from running out by writing to the reload register. The count steps down once per tick. A tick generator derives the tick from the input clock. A mode input picks one of two tick periods: a fractional legacy period of 0.6 s, or a whole second, in which case the count reads directly in seconds.

Running out once does not reset the system. The first expiry only raises a status flag and reloads the counter. A second expiry, reached while that first flag is still set, raises a second flag and drives a fixed-length system reset pulse. A no-reboot control bit suppresses that pulse, and both flags still record the event. When a pulse ends, the counter reloads and both flags clear. Both flags sit in one status word and are cleared by writing 1 to them.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the control register reads 1 (halt bit 0 set, no-reboot bit 1 clear), the timeout and the live count both read INIT_TMO, the status word reads 0 and `sys_rst_o` is low.
- R2: A write to the timeout register (address 1) stores data bits [9:0] only when that value is 4 or more. A value from 0 to 3 is ignored and the previous timeout is kept. Bits [15:10] are not stored and read as 0.
- R3: Any write to the reload register (address 2) loads the count with the programmed timeout, whatever the data. A read of address 2 returns the live count in bits [9:0], with all upper bits 0.
- R4: While running, the count drops by one every CLK_HZ*6/10 clock cycles when `tick_mode_i` is 0, and every CLK_HZ cycles when it is 1. The tick phase restarts at each reload, each halt release and the end of each reset pulse.
- R5: A tick that finds the count at 0 while the first-timeout flag (status bit 3) is clear sets that flag and reloads the count. The count therefore runs out timeout+1 ticks after a reload.
- R6: A tick that finds the count at 0 while status bit 3 is still set sets the second-timeout flag (status bit 17). If the no-reboot bit is clear, it also starts a reset pulse. Clearing bit 3 between expiries keeps the next expiry a first one.
- R7: Writing the status word (address 3) clears each flag whose bit is 1 in the data and leaves flags written with 0 unchanged. Writing 0x20008 clears both flags.
- R8: The no-reboot bit (control bit 1) reads back as written. While it is set, a second expiry sets bit 17 but `sys_rst_o` stays low and counting continues.
- R9: While the halt bit (control bit 0) is set, the count holds its value. Clearing the halt bit reloads the count before counting resumes.
- R10: The reset pulse is high for exactly RST_CYCLES cycles. In the cycle it ends, both flags clear and the count reloads with the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_mode_i | input | 1 | Tick period select: 0 = 0.6 s, 1 = 1 s |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address: 0 control, 1 timeout, 2 reload/count, 3 status |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bound checker runs on every cycle. It checks that the timeout never falls below 4 and that the count only steps down by one or jumps to the timeout. It also checks that a halted count stays still, that a reset pulse only follows a second expiry with no-reboot clear and lasts exactly the programmed length, and that the first flag only falls on a clear write or at the end of a pulse. The bench scenarios show the things those properties cannot pin down. These are the exact cycle of each decrement in both tick modes, the timeout+1 tick spacing of the two expiries, and the rejection of timeout values below 4. They also cover write-1-to-clear with mixed masks, and the rule that clearing the first flag between expiries stops a reset.

// File: rtl/wdt_two_stage_pkg.sv
// Package: register addresses, bit positions and the decoded command bundle
// shared by the watchdog modules. Assumes a 2-bit word address.
package wdt_two_stage_pkg;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_TMO    = 2'd1;
    localparam logic [1:0] ADDR_RELOAD = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;

    localparam int CTRL_HALT_BIT   = 0;
    localparam int CTRL_NORBT_BIT  = 1;
    localparam int ST_FIRST_BIT    = 3;
    localparam int ST_SECOND_BIT   = 17;

    // One-cycle commands decoded from a bus write.
    typedef struct packed {
        logic reload;
        logic halt_release;
        logic clr_first;
        logic clr_second;
    } wdt_cmd_t;

endpackage

// File: rtl/wdt_tick_gen.sv
// Tick generator: divides the clock down to the watchdog tick.
// Mode 0 gives a period of CLK_HZ*6/10 cycles and mode 1 a period of CLK_HZ
// cycles. clear_i holds the phase at zero and masks the tick.
// Assumes CLK_HZ >= 2 so both periods are at least one cycle.
module wdt_tick_gen #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mode_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam int LEGACY_DIV = (CLK_HZ * 6) / 10;
    localparam int WHOLE_DIV  = CLK_HZ;
    localparam int PRE_W      = $clog2(WHOLE_DIV + 1);
    localparam logic [PRE_W-1:0] LEGACY_LAST = PRE_W'(LEGACY_DIV - 1);
    localparam logic [PRE_W-1:0] WHOLE_LAST  = PRE_W'(WHOLE_DIV - 1);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] last_w;

    // Pick the terminal phase for the selected tick period.
    always_comb begin
        last_w = mode_i ? WHOLE_LAST : LEGACY_LAST;
    end

    // The tick fires on the terminal phase. ">=" also covers a mode switch
    // to a shorter period.
    assign tick_o = !clear_i && (phase_q >= last_w);

    // Phase counter: restart on clear or on a tick, otherwise advance.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i || tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_regs.sv
// Register block: holds the control bits and the timeout, decodes bus writes
// into one-cycle commands, and muxes read data.
// Assumes DATA_W > ST_SECOND_BIT and INIT_TMO >= MIN_TMO.
module wdt_regs
    import wdt_two_stage_pkg::*;
#(
    parameter int TMO_W    = 10,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int INIT_TMO = 30,
    parameter int MIN_TMO  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [TMO_W-1:0]  count_i,
    input  logic              first_i,
    input  logic              second_i,
    output logic [TMO_W-1:0]  tmo_o,
    output logic              halt_o,
    output logic              norbt_o,
    output wdt_cmd_t          cmd_o
);
    localparam logic [TMO_W-1:0] TMO_FLOOR = TMO_W'(MIN_TMO);
    localparam logic [TMO_W-1:0] TMO_RESET = TMO_W'(INIT_TMO);

    logic [TMO_W-1:0] tmo_q;
    logic             halt_q;
    logic             norbt_q;
    logic             wr_ctrl, wr_tmo, wr_reload, wr_status;
    logic             unused_wdata;

    // Address decode of a write strobe.
    always_comb begin
        wr_ctrl   = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_CTRL));
        wr_tmo    = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_TMO));
        wr_reload = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_RELOAD));
        wr_status = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_STATUS));
    end

    // Bits of the write data that no register keeps.
    assign unused_wdata = ^bus_wdata_i;

    // Timeout register: keeps only values at or above the floor.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tmo_q <= TMO_RESET;
        end else if (wr_tmo && (bus_wdata_i[TMO_W-1:0] >= TMO_FLOOR)) begin
            tmo_q <= bus_wdata_i[TMO_W-1:0];
        end
    end

    // Control register: halt (set at reset) and no-reboot.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            halt_q  <= 1'b1;
            norbt_q <= 1'b0;
        end else if (wr_ctrl) begin
            halt_q  <= bus_wdata_i[CTRL_HALT_BIT];
            norbt_q <= bus_wdata_i[CTRL_NORBT_BIT];
        end
    end

    // One-cycle commands for the expiry core.
    always_comb begin
        cmd_o.reload       = wr_reload;
        cmd_o.halt_release = wr_ctrl && halt_q && !bus_wdata_i[CTRL_HALT_BIT];
        cmd_o.clr_first    = wr_status && bus_wdata_i[ST_FIRST_BIT];
        cmd_o.clr_second   = wr_status && bus_wdata_i[ST_SECOND_BIT];
    end

    // Read mux; unused bits read as zero.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(ADDR_CTRL): begin
                bus_rdata_o[CTRL_HALT_BIT]  = halt_q;
                bus_rdata_o[CTRL_NORBT_BIT] = norbt_q;
            end
            ADDR_W'(ADDR_TMO):    bus_rdata_o[TMO_W-1:0] = tmo_q;
            ADDR_W'(ADDR_RELOAD): bus_rdata_o[TMO_W-1:0] = count_i;
            default: begin
                bus_rdata_o[ST_FIRST_BIT]  = first_i;
                bus_rdata_o[ST_SECOND_BIT] = second_i;
            end
        endcase
    end

    assign tmo_o   = tmo_q;
    assign halt_o  = halt_q;
    assign norbt_o = norbt_q;

endmodule

// File: rtl/wdt_expiry_core.sv
// Expiry core: the down-counter, the two timeout flags and the reset pulse.
// Assumes tick_i is already masked while halted, during a pulse and on a
// reload cycle (the tick generator's clear does this).
module wdt_expiry_core
    import wdt_two_stage_pkg::*;
#(
    parameter int TMO_W      = 10,
    parameter int INIT_TMO   = 30,
    parameter int RST_CYCLES = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [TMO_W-1:0] tmo_i,
    input  logic             norbt_i,
    input  wdt_cmd_t         cmd_i,
    output logic [TMO_W-1:0] count_o,
    output logic             first_o,
    output logic             second_o,
    output logic             pulse_o
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);
    localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RST_CYCLES);
    localparam logic [RC_W-1:0] RC_ONE  = RC_W'(1);

    logic [TMO_W-1:0] count_q;
    logic             first_q, second_q;
    logic [RC_W-1:0]  rc_q;
    logic             expire, second_exp, pulse_on, pulse_end;

    // Event decode for this cycle.
    always_comb begin
        expire     = tick_i && (count_q == '0);
        second_exp = expire && first_q;
        pulse_on   = (rc_q != '0);
        pulse_end  = (rc_q == RC_ONE);
    end

    // Down-counter: reload on command, expiry or pulse end; step on a tick.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= TMO_W'(INIT_TMO);
        end else if (cmd_i.reload || cmd_i.halt_release || pulse_end || expire) begin
            count_q <= tmo_i;
        end else if (tick_i) begin
            count_q <= count_q - 1'b1;
        end
    end

    // First-timeout flag: an expiry sets it, a clear write drops it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || pulse_end) begin
            first_q <= 1'b0;
        end else if (expire) begin
            first_q <= 1'b1;
        end else if (cmd_i.clr_first) begin
            first_q <= 1'b0;
        end
    end

    // Second-timeout flag: set by an expiry that finds the first flag set.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || pulse_end) begin
            second_q <= 1'b0;
        end else if (second_exp) begin
            second_q <= 1'b1;
        end else if (cmd_i.clr_second) begin
            second_q <= 1'b0;
        end
    end

    // Reset pulse length counter, armed by a second expiry without no-reboot.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rc_q <= '0;
        end else if (second_exp && !norbt_i) begin
            rc_q <= RC_LOAD;
        end else if (pulse_on) begin
            rc_q <= rc_q - 1'b1;
        end
    end

    assign count_o  = count_q;
    assign first_o  = first_q;
    assign second_o = second_q;
    assign pulse_o  = pulse_on;

endmodule

// File: rtl/wdt_two_stage.sv
// Top: two-stage watchdog. Joins the register block, the tick generator and
// the expiry core. Assumes a single clock and a synchronous active-low reset.
module wdt_two_stage
    import wdt_two_stage_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int TMO_W      = 10,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter int INIT_TMO   = 30,
    parameter int MIN_TMO    = 4,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_mode_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              sys_rst_o
);
    logic [TMO_W-1:0] count_w;
    logic [TMO_W-1:0] tmo_w;
    logic             first_w, second_w;
    logic             halt_w, norbt_w;
    logic             tick_w, pulse_w, tick_clr_w;
    wdt_cmd_t         cmd_w;

    // Tick phase restarts whenever the count is reloaded or frozen.
    assign tick_clr_w = halt_w || cmd_w.reload || pulse_w;

    wdt_regs #(
        .TMO_W(TMO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .INIT_TMO(INIT_TMO), .MIN_TMO(MIN_TMO)
    ) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .count_i(count_w), .first_i(first_w), .second_i(second_w),
        .tmo_o(tmo_w), .halt_o(halt_w), .norbt_o(norbt_w), .cmd_o(cmd_w)
    );

    wdt_tick_gen #(
        .CLK_HZ(CLK_HZ)
    ) tick_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(tick_mode_i),
        .clear_i(tick_clr_w), .tick_o(tick_w)
    );

    wdt_expiry_core #(
        .TMO_W(TMO_W), .INIT_TMO(INIT_TMO), .RST_CYCLES(RST_CYCLES)
    ) core_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w),
        .tmo_i(tmo_w), .norbt_i(norbt_w), .cmd_i(cmd_w),
        .count_o(count_w), .first_o(first_w), .second_o(second_w),
        .pulse_o(pulse_w)
    );

    assign sys_rst_o = pulse_w;

endmodule

// File: rtl/wdt_two_stage_chk.sv
// Checker: cycle-by-cycle properties of the watchdog, bound to the top.
// Assumes it sees the top's internal count, timeout, control and flag nets.
module wdt_two_stage_chk
    import wdt_two_stage_pkg::*;
#(
    parameter int TMO_W      = 10,
    parameter int MIN_TMO    = 4,
    parameter int RST_CYCLES = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [TMO_W-1:0] count_i,
    input logic [TMO_W-1:0] tmo_i,
    input logic             halt_i,
    input logic             norbt_i,
    input logic             first_i,
    input logic             second_i,
    input logic             sys_rst_i,
    input wdt_cmd_t         cmd_i
);
    localparam int HL_W = $clog2(RST_CYCLES + 2);
    localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

    logic [HL_W-1:0] hi_len;

    // Length of the current run of high reset-pulse cycles.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !sys_rst_i) hi_len <= '0;
        else                       hi_len <= hi_len + 1'b1;
    end

    p_tmo_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_i >= TMO_W'(MIN_TMO));

    p_count_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_i != $past(count_i)) |->
            ((count_i == ($past(count_i) - ONE)) || (count_i == $past(tmo_i))));

    p_halt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_i && $past(halt_i) && !$past(cmd_i.reload) && !$past(sys_rst_i))
            |-> $stable(count_i));

    p_rst_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sys_rst_i) |-> (first_i && second_i && !$past(norbt_i)));

    p_norbt_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (norbt_i && $past(norbt_i) && !$past(sys_rst_i)) |-> !sys_rst_i);

    p_first_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(first_i) |-> ($past(cmd_i.clr_first) || $past(sys_rst_i)));

    p_pulse_max_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_i |-> (hi_len < HL_W'(RST_CYCLES)));

    p_pulse_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sys_rst_i) |-> (hi_len == HL_W'(RST_CYCLES)));

    p_pulse_end_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sys_rst_i) |-> (!first_i && !second_i && count_i == tmo_i));

endmodule

bind wdt_two_stage wdt_two_stage_chk #(
    .TMO_W(TMO_W), .MIN_TMO(MIN_TMO), .RST_CYCLES(RST_CYCLES)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count_w), .tmo_i(tmo_w),
    .halt_i(halt_w), .norbt_i(norbt_w), .first_i(first_w),
    .second_i(second_w), .sys_rst_i(sys_rst_o), .cmd_i(cmd_w)
);

// File: tb/wdt_two_stage_tb_top.sv
// Scoreboard bench: driver tasks queue expected values, a negedge monitor
// pops and compares them against the ports.
module wdt_two_stage_tb_top;
    localparam int CLK_HZ = 10;   // legacy tick 6 cycles, whole tick 10 cycles
    localparam int INIT   = 8;
    localparam int RSTC   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b1;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        sys_rst;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_wr = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_rst;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    wdt_two_stage #(.CLK_HZ(CLK_HZ), .INIT_TMO(INIT), .RST_CYCLES(RSTC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_mode_i(mode), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .sys_rst_o(sys_rst)
    );

    // Monitor: compare one queued expectation per cycle, away from the edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_rst ? {31'd0, sys_rst} : rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0; wdata = 32'd0;
        last_wr = cyc;
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        addr = a;
        it.is_rst = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic exp_rst(input logic e, input string tag);
        item_t it;
        it.is_rst = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic wait_past(input int target);
        while (cyc < target) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        int s0, w2, x, w3, h;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        exp_rd(2'd0, 32'h1, "R1 ctrl");
        exp_rd(2'd1, INIT, "R1 timeout");
        exp_rd(2'd2, INIT, "R1 count");
        exp_rd(2'd3, 32'h0, "R1 status");
        exp_rst(1'b0, "R1 sys_rst");

        // R2 timeout writes
        wr_reg(2'd1, 32'hA405); exp_rd(2'd1, 32'h005, "R2 low bits only");
        wr_reg(2'd1, 32'h3);    exp_rd(2'd1, 32'h005, "R2 value 3 ignored");
        wr_reg(2'd1, 32'h402);  exp_rd(2'd1, 32'h005, "R2 low value 2 ignored");
        wr_reg(2'd1, 32'h4);    exp_rd(2'd1, 32'h004, "R2 value 4 kept");
        wr_reg(2'd1, 32'h3FF);  exp_rd(2'd1, 32'h3FF, "R2 max kept");
        wr_reg(2'd1, 32'h5);

        // R9 halted count holds
        wait_past(cyc + 25);
        exp_rd(2'd2, INIT, "R9 halted hold");

        // R9 release reloads; R4 whole-second ticks
        wr_reg(2'd0, 32'h0); s0 = last_wr;
        exp_rd(2'd2, 5, "R9 release reload");
        wait_past(s0 + 9);  exp_rd(2'd2, 5, "R4 before first tick");
        exp_rd(2'd2, 4, "R4 first tick mode1");

        // R3 reload with arbitrary data
        wait_past(s0 + 25);
        wr_reg(2'd2, 32'hDEAD); w2 = last_wr;
        exp_rd(2'd2, 5, "R3 reload value");

        // R5 first expiry
        wait_past(w2 + 59); exp_rd(2'd2, 0, "R5 count at zero");
        exp_rd(2'd3, 32'h8, "R5 first flag");
        exp_rd(2'd2, 5, "R5 reload on expiry");
        wr_reg(2'd3, 32'h0); exp_rd(2'd3, 32'h8, "R7 write 0 no effect");

        // R6 second expiry, R10 pulse
        wait_past(w2 + 119); exp_rst(1'b0, "R6 no pulse before second expiry");
        exp_rd(2'd3, 32'h20008, "R6 both flags");
        exp_rst(1'b1, "R6 pulse start");
        wait_past(w2 + 123); exp_rst(1'b1, "R10 pulse last cycle");
        exp_rst(1'b0, "R10 pulse ended");
        exp_rd(2'd3, 32'h0, "R10 flags cleared");
        exp_rd(2'd2, 5, "R10 count reloaded");
        x = w2 + 124;

        // R8 no-reboot
        wr_reg(2'd0, 32'h2); exp_rd(2'd0, 32'h2, "R8 readback");
        wait_past(x + 120); exp_rd(2'd3, 32'h20008, "R8 flags recorded");
        exp_rst(1'b0, "R8 pulse blocked");
        wait_past(x + 124); exp_rst(1'b0, "R8 still no pulse");
        exp_rd(2'd2, 5, "R8 counting continues");
        wr_reg(2'd3, 32'h20008); exp_rd(2'd3, 32'h0, "R7 clear both");

        // R6 clearing first flag keeps the next expiry a first one
        wait_past(x + 180); exp_rd(2'd3, 32'h8, "R6 non-consecutive");
        wr_reg(2'd3, 32'h20000); exp_rd(2'd3, 32'h8, "R7 mask keeps bit3");
        wr_reg(2'd3, 32'h8);     exp_rd(2'd3, 32'h0, "R7 bit3 cleared");

        // R4 legacy ticks
        mode = 1'b0;
        wr_reg(2'd2, 32'h0); w3 = last_wr;
        wait_past(w3 + 5); exp_rd(2'd2, 5, "R4 legacy before tick");
        exp_rd(2'd2, 4, "R4 legacy tick");

        // R9 halt mid-count
        wr_reg(2'd0, 32'h3); h = last_wr;
        wait_past(h + 30); exp_rd(2'd2, 4, "R9 halt holds count");
        exp_rd(2'd0, 32'h3, "R9 ctrl halted");
        wr_reg(2'd0, 32'h2); exp_rd(2'd2, 5, "R9 release reloads");

        @(posedge clk); #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule